// File: doc/BRIEF.md
# Protection Register and Lock Controller

This block sits beside a two-wire serial memory slave and owns the eight-bit protection register that answers at the highest array address. Two volatile enable latches gate all software writes. Three persistent bits hold a lock map and a hardware-protect enable. The slave reports each completed write transaction with a strobe, the target address, the data byte and a flag that marks a one-byte transfer. The block decodes the transaction against the unlock sequence and, for a persistent update, runs a timed commit cycle and raises a busy flag while it runs.

The block also answers three questions about the address on its `addr` port. Does a program request there pass the lock map? May the slave acknowledge a data byte? Should a read return the register or the array byte? The persistent bits are modelled by flops that the power-on reset does not touch. A reset therefore clears only the two enable latches. The register is cleared, like the array, only through the unlock sequence.

Top module: `prot_reg_ctrl`

## Requirements
- R1: After power-on reset, `busy` is 0 and register bits 6, 5, 2, 1 and 0 read as 0.
- R2: `reg_rdata` is {hw-enable, 0, 0, map[1], map[0], reg-enable latch, write-enable latch, 0}, with bit 7 the most significant.
- R3: A one-byte write of 0000001x to the top address sets the write-enable latch (bit 1). A one-byte write of 00000000 clears both latches.
- R4: A one-byte write of w00yz11x to the top address sets the reg-enable latch (bit 2) only while bit 1 is set, and leaves bits 7, 4 and 3 unchanged.
- R5: A one-byte write of w00yz01x to the top address while bit 2 is set clears bit 2 and holds `busy` high for NV_CYCLES cycles. Bit 7 then reads w and bits 4:3 read yz. The same byte with bit 2 clear changes no persistent bit and starts no cycle.
- R6: While `busy` is high, `ack_ok` and `wr_ok` are 0 and write strobes are ignored.
- R7: When idle, `ack_ok` is 1 if the write-enable latch is set or `addr` is the top address, and 0 otherwise.
- R8: When idle, `wr_ok` is 1 only if the write-enable latch is set and `addr` lies outside the locked region. Map 00 locks nothing, 01 locks the addresses whose two top bits are 11, 10 locks the addresses whose top bit is 1, and 11 locks every array address, including the array byte at the top address.
- R9: While `pp_pin` is 1 and bit 7 is 1, a persistent update request changes nothing and starts no cycle; it also leaves bit 2 set. With `pp_pin` at 0 the same request proceeds.
- R10: A write strobe with `wr_single` at 0 leaves the register unchanged, even at the top address.
- R11: Bits 7, 4 and 3 keep their value across a power-on reset.
- R12: `rd_reg_sel` is 1 exactly when `rd_first` is 1 and `addr` is the top address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| wr_stb | input | 1 | One-cycle pulse: a write transaction has completed |
| wr_single | input | 1 | The completed transaction carried exactly one data byte |
| addr | input | ADDR_W | Target address for the strobe and for the permission queries |
| wr_byte | input | 8 | Data byte of the completed one-byte write |
| pp_pin | input | 1 | Hardware program-protect pin |
| rd_first | input | 1 | The byte about to be read is the first one after an address phase |
| reg_rdata | output | 8 | Protection register read value |
| rd_reg_sel | output | 1 | The slave should return the register instead of the array byte |
| wr_ok | output | 1 | Program request at `addr` is permitted |
| ack_ok | output | 1 | The slave may acknowledge a data byte aimed at `addr` |
| busy | output | 1 | Persistent commit cycle in progress |

## Verification
The assertions assume that `wr_stb` is a single-cycle pulse and that `addr`, `wr_byte` and `wr_single` are stable in the cycle of the strobe. They also assume that `pp_pin` changes only between transactions. The bench drives every input just after a rising edge and holds it for at least one full cycle. It never changes `pp_pin` while a strobe is pending. It releases reset one cycle clear of an edge, so the internal reset synchronizer sees a clean release.

// File: rtl/prot_reg_pkg.sv
package prot_reg_pkg;

  localparam int unsigned REG_W = 8;

  typedef enum logic [1:0] {
    LOCK_NONE    = 2'b00,
    LOCK_QUARTER = 2'b01,
    LOCK_HALF    = 2'b10,
    LOCK_ALL     = 2'b11
  } lock_map_e;

  typedef struct packed {
    logic      hw_en;
    lock_map_e map;
  } nv_bits_t;

endpackage

// File: rtl/prot_reg_decode.sv
module prot_reg_decode
  import prot_reg_pkg::*;
(
  input  logic             cmd_vld,
  input  logic [REG_W-1:0] cmd_byte,
  input  logic             wel_q,
  input  logic             rwel_q,
  input  logic             hw_lock,
  output logic             set_wel,
  output logic             clr_vol,
  output logic             set_rwel,
  output logic             nv_start
);

  logic fmt_ok;

  always_comb begin
    fmt_ok   = (cmd_byte[6:5] == 2'b00);
    set_wel  = 1'b0;
    clr_vol  = 1'b0;
    set_rwel = 1'b0;
    nv_start = 1'b0;
    if (cmd_vld) begin
      if (cmd_byte == '0) begin
        clr_vol = 1'b1;
      end else if (fmt_ok && (cmd_byte[2:1] == 2'b01) && rwel_q) begin
        // persistent update: refused entirely under hardware protection
        nv_start = !hw_lock;
      end else if (cmd_byte[7:1] == 7'b0000001) begin
        set_wel = 1'b1;
      end else if (fmt_ok && (cmd_byte[2:1] == 2'b11) && wel_q) begin
        set_rwel = 1'b1;
      end
    end
  end

endmodule

// File: rtl/prot_reg_lockmap.sv
module prot_reg_lockmap
  import prot_reg_pkg::*;
#(
  parameter int unsigned ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr,
  input  lock_map_e         map,
  output logic              locked
);

  localparam int unsigned MSB = ADDR_W - 1;

  logic top_half;
  logic top_quarter;

  generate
    if (ADDR_W >= 2) begin : g_wide
      assign top_half    = addr[MSB];
      assign top_quarter = &addr[MSB -: 2];
    end else begin : g_narrow
      assign top_half    = addr[MSB];
      assign top_quarter = addr[MSB];
    end
  endgenerate

  always_comb begin
    unique case (map)
      LOCK_NONE:    locked = 1'b0;
      LOCK_QUARTER: locked = top_quarter;
      LOCK_HALF:    locked = top_half;
      default:      locked = 1'b1;
    endcase
  end

endmodule

// File: rtl/prot_reg_nvcell.sv
module prot_reg_nvcell
  import prot_reg_pkg::*;
#(
  parameter int unsigned NV_CYCLES = 1000
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     start,
  input  nv_bits_t load_val,
  output nv_bits_t nv_q,
  output logic     busy
);

  localparam int unsigned CNT_W = $clog2(NV_CYCLES + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             busy_q, busy_d;
  logic             commit;
  logic             cnt_en;
  nv_bits_t         pend_q;

  always_comb begin
    cnt_d  = cnt_q;
    busy_d = busy_q;
    commit = 1'b0;
    if (busy_q) begin
      if (cnt_q == '0) begin
        busy_d = 1'b0;
        commit = 1'b1;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end else if (start) begin
      busy_d = 1'b1;
      cnt_d  = CNT_W'(NV_CYCLES - 1);
    end
    cnt_en = busy_q || start;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (cnt_en) begin
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
    end
  end

  // staging and persistent flops: untouched by the volatile reset
  always_ff @(posedge clk) begin
    if (start && !busy_q) pend_q <= load_val;
  end

  always_ff @(posedge clk) begin
    if (commit) nv_q <= pend_q;
  end

  assign busy = busy_q;

  AST_BUSY_RUNS_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && (cnt_q != '0)) |=> busy_q);                            // R5
  AST_NV_STABLE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && !$past(busy_q)) |-> $stable(nv_q));                    // R5

endmodule

// File: rtl/prot_reg_ctrl.sv
module prot_reg_ctrl
  import prot_reg_pkg::*;
#(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned NV_CYCLES = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic              wr_single,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wr_byte,
  input  logic              pp_pin,
  input  logic              rd_first,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              rd_reg_sel,
  output logic              wr_ok,
  output logic              ack_ok,
  output logic              busy
);

  localparam logic [ADDR_W-1:0] TOP_ADDR = {ADDR_W{1'b1}};

  logic [1:0] rst_sync_q;
  logic       rst_n_int;
  logic       at_top;
  logic       cmd_vld;
  logic       hw_lock;
  logic       set_wel, clr_vol, set_rwel, nv_start;
  logic       wel_q, wel_d, rwel_q, rwel_d, vol_en;
  logic       locked;
  nv_bits_t   nv_q;
  nv_bits_t   load_val;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  assign at_top   = (addr == TOP_ADDR);
  assign cmd_vld  = wr_stb && wr_single && at_top && !busy;
  assign hw_lock  = pp_pin && nv_q.hw_en;
  assign load_val = '{hw_en: wr_byte[7], map: lock_map_e'(wr_byte[4:3])};

  prot_reg_decode u_decode (
    .cmd_vld  (cmd_vld),
    .cmd_byte (wr_byte),
    .wel_q    (wel_q),
    .rwel_q   (rwel_q),
    .hw_lock  (hw_lock),
    .set_wel  (set_wel),
    .clr_vol  (clr_vol),
    .set_rwel (set_rwel),
    .nv_start (nv_start)
  );

  prot_reg_nvcell #(.NV_CYCLES(NV_CYCLES)) u_nvcell (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .start    (nv_start),
    .load_val (load_val),
    .nv_q     (nv_q),
    .busy     (busy)
  );

  prot_reg_lockmap #(.ADDR_W(ADDR_W)) u_lockmap (
    .addr   (addr),
    .map    (nv_q.map),
    .locked (locked)
  );

  always_comb begin
    wel_d  = wel_q;
    rwel_d = rwel_q;
    if (clr_vol) begin
      wel_d  = 1'b0;
      rwel_d = 1'b0;
    end
    if (set_wel)  wel_d  = 1'b1;
    if (set_rwel) rwel_d = 1'b1;
    if (nv_start) rwel_d = 1'b0;
    vol_en = clr_vol || set_wel || set_rwel || nv_start;
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      wel_q  <= 1'b0;
      rwel_q <= 1'b0;
    end else if (vol_en) begin
      wel_q  <= wel_d;
      rwel_q <= rwel_d;
    end
  end

  assign reg_rdata  = {nv_q.hw_en, 2'b00, nv_q.map, rwel_q, wel_q, 1'b0};
  assign rd_reg_sel = rd_first && at_top;
  assign ack_ok     = !busy && (wel_q || at_top);
  assign wr_ok      = !busy && wel_q && !locked;

  AST_RWEL_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n_int)
    rwel_q |-> wel_q);                                                 // R4
  AST_LOAD_DROPS_RWEL: assert property (@(posedge clk) disable iff (!rst_n_int)
    $rose(busy) |-> !rwel_q);                                          // R5
  AST_HW_REFUSES_LOAD: assert property (@(posedge clk) disable iff (!rst_n_int)
    $rose(busy) |-> !($past(pp_pin) && $past(nv_q.hw_en)));            // R9
  AST_BUSY_FREEZES_LATCHES: assert property (@(posedge clk) disable iff (!rst_n_int)
    (busy && $past(busy)) |-> ($stable(wel_q) && $stable(rwel_q)));    // R6

endmodule

// File: tb/prot_reg_ctrl_bench.sv
module prot_reg_ctrl_bench;

  localparam int unsigned ADDR_W = 12;
  localparam int unsigned NV_CYC = 20;
  localparam logic [ADDR_W-1:0] TOP = {ADDR_W{1'b1}};

  localparam int SEL_RD   = 0;
  localparam int SEL_BUSY = 1;
  localparam int SEL_ACK  = 2;
  localparam int SEL_WROK = 3;
  localparam int SEL_RSEL = 4;
  localparam int SEL_RDM  = 5;

  typedef struct {
    int         rid;
    int         sel;
    logic [7:0] exp;
  } exp_item_t;

  logic              clk;
  logic              rst_n;
  logic              wr_stb;
  logic              wr_single;
  logic [ADDR_W-1:0] addr;
  logic [7:0]        wr_byte;
  logic              pp_pin;
  logic              rd_first;
  logic [7:0]        reg_rdata;
  logic              rd_reg_sel;
  logic              wr_ok;
  logic              ack_ok;
  logic              busy;

  exp_item_t sb_q[$];
  int n_cmp;
  int n_bad;
  bit done;

  prot_reg_ctrl #(.ADDR_W(ADDR_W), .NV_CYCLES(NV_CYC)) u_prot_reg_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_single(wr_single),
    .addr(addr), .wr_byte(wr_byte), .pp_pin(pp_pin), .rd_first(rd_first),
    .reg_rdata(reg_rdata), .rd_reg_sel(rd_reg_sel), .wr_ok(wr_ok),
    .ack_ok(ack_ok), .busy(busy)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // monitor: pops expectations and compares at the falling edge
  always @(negedge clk) begin
    while (sb_q.size() > 0) begin
      exp_item_t it;
      logic [7:0] act;
      it = sb_q.pop_front();
      case (it.sel)
        SEL_RD:   act = reg_rdata;
        SEL_BUSY: act = {7'd0, busy};
        SEL_ACK:  act = {7'd0, ack_ok};
        SEL_WROK: act = {7'd0, wr_ok};
        SEL_RSEL: act = {7'd0, rd_reg_sel};
        default:  act = reg_rdata & 8'h67;
      endcase
      n_cmp++;
      if (act !== it.exp) begin
        n_bad++;
        $display("FAIL R%0d sel=%0d actual=%02h expected=%02h", it.rid, it.sel, act, it.exp);
      end
    end
  end

  task automatic expect_val(input int rid, input int sel, input logic [7:0] exp);
    exp_item_t it;
    it.rid = rid; it.sel = sel; it.exp = exp;
    sb_q.push_back(it);
    @(negedge clk);
    #1;
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [7:0] b, input logic single);
    @(posedge clk); #1;
    addr = a; wr_byte = b; wr_single = single; wr_stb = 1'b1;
    @(posedge clk); #1;
    wr_stb = 1'b0; wr_single = 1'b1;
  endtask

  task automatic wait_nv();
    repeat (NV_CYC + 3) @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    @(posedge clk); #1;
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    n_cmp = 0; n_bad = 0; done = 0;
    rst_n = 1'b0; wr_stb = 1'b0; wr_single = 1'b1; addr = '0;
    wr_byte = '0; pp_pin = 1'b0; rd_first = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;

    // R1: volatile and fixed-zero bits after reset
    expect_val(1, SEL_RDM, 8'h00);
    expect_val(1, SEL_BUSY, 8'h00);

    // R3: set write-enable
    wr(TOP, 8'h02, 1'b1);
    expect_val(3, SEL_RDM, 8'h02);
    // R4: set reg-enable
    wr(TOP, 8'h06, 1'b1);
    expect_val(4, SEL_RDM, 8'h06);
    // R5: load all-zero persistent bits
    wr(TOP, 8'h02, 1'b1);
    expect_val(5, SEL_BUSY, 8'h01);
    expect_val(5, SEL_RDM, 8'h02);
    // R6: no ack, no permit, strobe ignored while busy
    addr = 12'h100;
    expect_val(6, SEL_ACK, 8'h00);
    expect_val(6, SEL_WROK, 8'h00);
    wr(TOP, 8'h00, 1'b1);
    expect_val(6, SEL_RDM, 8'h02);
    wait_nv();
    // R2: full register image after commit
    expect_val(2, SEL_BUSY, 8'h00);
    expect_val(2, SEL_RD, 8'h02);

    // R7 / R8: write-enable set, nothing locked
    addr = 12'h100;
    expect_val(7, SEL_ACK, 8'h01);
    expect_val(8, SEL_WROK, 8'h01);

    // R3: clear latches
    wr(TOP, 8'h00, 1'b1);
    expect_val(3, SEL_RD, 8'h00);
    addr = 12'h100;
    expect_val(7, SEL_ACK, 8'h00);
    expect_val(8, SEL_WROK, 8'h00);
    addr = TOP;
    expect_val(7, SEL_ACK, 8'h01);

    // R4: reg-enable refused without write-enable
    wr(TOP, 8'h06, 1'b1);
    expect_val(4, SEL_RD, 8'h00);

    // R5: load pattern without reg-enable is ignored
    wr(TOP, 8'h02, 1'b1);
    wr(TOP, 8'h9A, 1'b1);
    expect_val(5, SEL_BUSY, 8'h00);
    expect_val(5, SEL_RD, 8'h02);

    // R4: w00yz110 only sets reg-enable
    wr(TOP, 8'h8E, 1'b1);
    expect_val(4, SEL_RD, 8'h06);

    // R5 / R8: quarter lock
    wr(TOP, 8'h0A, 1'b1);
    expect_val(5, SEL_BUSY, 8'h01);
    wait_nv();
    expect_val(5, SEL_RD, 8'h0A);
    addr = 12'hC00;
    expect_val(8, SEL_WROK, 8'h00);
    addr = 12'hBFF;
    expect_val(8, SEL_WROK, 8'h01);
    addr = TOP;
    expect_val(8, SEL_WROK, 8'h00);

    // R10: multi-byte write at top leaves register alone
    wr(TOP, 8'h00, 1'b0);
    expect_val(10, SEL_RD, 8'h0A);

    // R8: half lock
    wr(TOP, 8'h06, 1'b1);
    wr(TOP, 8'h12, 1'b1);
    wait_nv();
    expect_val(8, SEL_RD, 8'h12);
    addr = 12'h800;
    expect_val(8, SEL_WROK, 8'h00);
    addr = 12'h7FF;
    expect_val(8, SEL_WROK, 8'h01);

    // R8: full lock with hardware enable bit
    wr(TOP, 8'h06, 1'b1);
    wr(TOP, 8'h9A, 1'b1);
    wait_nv();
    expect_val(8, SEL_RD, 8'h9A);
    addr = 12'h000;
    expect_val(8, SEL_WROK, 8'h00);

    // R9: pin high refuses persistent update
    pp_pin = 1'b1;
    wr(TOP, 8'h06, 1'b1);
    expect_val(9, SEL_RD, 8'h9E);
    wr(TOP, 8'h82, 1'b1);
    expect_val(9, SEL_BUSY, 8'h00);
    expect_val(9, SEL_RD, 8'h9E);
    // R9: pin low lets it through
    pp_pin = 1'b0;
    wr(TOP, 8'h02, 1'b1);
    expect_val(9, SEL_BUSY, 8'h01);
    wait_nv();
    expect_val(9, SEL_RD, 8'h02);

    // R11: persistent bits survive reset
    wr(TOP, 8'h06, 1'b1);
    wr(TOP, 8'h0A, 1'b1);
    wait_nv();
    do_reset();
    expect_val(11, SEL_RD, 8'h08);
    expect_val(11, SEL_BUSY, 8'h00);

    // R12: register select on first read byte at top only
    rd_first = 1'b1; addr = TOP;
    expect_val(12, SEL_RSEL, 8'h01);
    rd_first = 1'b0;
    expect_val(12, SEL_RSEL, 8'h00);
    rd_first = 1'b1; addr = 12'h010;
    expect_val(12, SEL_RSEL, 8'h00);
    rd_first = 1'b0;

    repeat (2) @(posedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule